// File: doc/BRIEF.md
# Three-Wire Nibble Register Access Master

This block is the bus master for a peripheral that holds 4-bit registers and talks over three wires: a chip enable, a serial clock that idles high, and one data line shared by both directions. The host gives a register address, a write nibble and a read/write select, then pulses a start strobe. The block shifts out a 16-bit frame, one bit per serial clock pulse, and then reports completion.

Every frame opens with a control nibble and then the register address. A read releases the data line after the address. It clocks in eight bits, drops the first four and keeps the last four as the result. A write keeps driving the line. It sends a second control nibble and then the data nibble. The length of each half of a serial clock period is a parameter counted in system clock cycles. The chip enable is driven by the host through a separate input, and the block only registers it onto the pin.

Top module: `serial_nibble_master`

## Requirements
- R1: In reset and after it, `sclk` is 1, `sdOe` is 0, `sdOut` is 0, `busy` and `done` are 0 and `rdData` is 0.
- R2: Frame bits 0 to 3 form the first control nibble, in this order: 1, then the read flag (1 for a read, 0 for a write), then 1, then 0.
- R3: Frame bits 4 to 7 carry `regAddr`, most significant bit first.
- R4: In a read, `sdOe` is 0 from frame bit 8 onward. The bits sampled for frame bits 8 to 11 are discarded, and the bits sampled for frame bits 12 to 15 form `rdData` in that order, bit 3 first.
- R5: In a write, frame bits 8 to 11 are driven as 1, 0, 0, 1 and frame bits 12 to 15 carry `wrData`, most significant bit first.
- R6: Each frame bit lasts 2*HALF_CYC cycles. For the first HALF_CYC cycles `sclk` is 1 with the bit already driven, and for the next HALF_CYC cycles `sclk` is 0. Every access has exactly 16 low pulses.
- R7: An input bit is taken from `sdIn` on the last system clock edge before `sclk` falls for that bit.
- R8: `startReq` is ignored while `busy` is 1, including the cycle in which the last pulse ends.
- R9: `done` is 1 for exactly one cycle, the cycle in which `sclk` returns high after the 16th pulse, and `busy` is 0 in that same cycle.
- R10: `rdData` changes only when a read completes and otherwise holds its value. Writes leave it unchanged.
- R11: `ceOut` equals `ceIn` delayed by one clock cycle.
- R12: `sdOe` is 0 while idle and 1 from the first cycle of every access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Start strobe for one access |
| rdNotWr | input | 1 | 1 selects a read, 0 selects a write |
| regAddr | input | 4 | Register address |
| wrData | input | 4 | Nibble to write |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rdData | output | 4 | Last nibble read |
| ceIn | input | 1 | Host-controlled chip enable |
| ceOut | output | 1 | Chip enable pin |
| sclk | output | 1 | Serial clock, idles high |
| sdOut | output | 1 | Data line output value |
| sdOe | output | 1 | Data line output enable |
| sdIn | input | 1 | Data line input value |

## Verification
A wrong bit counter or phase counter moves the falling edges of `sclk` or changes the frame length. A reference model that runs in step with the design exposes this within one half period, and the failure shows on `sclk`, `busy` or `done`. A corrupted frame shift register or output-enable mask shows on `sdOut` or `sdOe` in the cycle of the bad bit. A wrong capture point or capture order stays hidden until the end of a read, when `rdData` takes a wrong value. To expose it, the responder drives discard bits that differ from the data bits.

// File: rtl/snm_pkg.sv
package snm_pkg;
  localparam int NIBBLE     = 4;
  localparam int FRAME_BITS = 4 * NIBBLE;
  localparam int DATA_FIRST = 3 * NIBBLE;

  // control nibbles, first bit sent is the MSB
  localparam logic [NIBBLE-1:0] CTL_READ     = 4'b1110;
  localparam logic [NIBBLE-1:0] CTL_WR_ADDR  = 4'b1010;
  localparam logic [NIBBLE-1:0] CTL_WR_DATA  = 4'b1001;

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_LOW} phase_e;

  typedef struct packed {
    logic load;     // capture a new frame
    logic advance;  // move to the next frame bit
    logic sample;   // take one input bit
    logic commit;   // publish captured nibble
  } snm_strobe_t;
endpackage

// File: rtl/snm_ctrl.sv
module snm_ctrl
  import snm_pkg::*;
#(
  parameter int HALF_CYC = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic        rdNotWr,
  output snm_strobe_t strb,
  output logic        busy,
  output logic        done,
  output logic        sclk
);
  localparam int CNT_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam int BIT_W = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(HALF_CYC - 1);
  localparam logic [BIT_W-1:0] BIT_LAST  = BIT_W'(FRAME_BITS - 1);
  localparam logic [BIT_W-1:0] BIT_DATA  = BIT_W'(DATA_FIRST);

  phase_e           phase;
  logic [CNT_W-1:0] halfCnt;
  logic [BIT_W-1:0] bitCnt;
  logic             isRead;
  logic             halfEnd;
  logic             lastBit;

  assign halfEnd = (halfCnt == HALF_LAST);
  assign lastBit = (bitCnt == BIT_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      halfCnt <= '0;
      bitCnt  <= '0;
      isRead  <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (phase)
        PH_IDLE: begin
          if (startReq) begin
            phase   <= PH_SETUP;
            halfCnt <= '0;
            bitCnt  <= '0;
            isRead  <= rdNotWr;
          end
        end
        PH_SETUP: begin
          if (halfEnd) begin
            halfCnt <= '0;
            phase   <= PH_LOW;
          end else begin
            halfCnt <= halfCnt + 1'b1;
          end
        end
        PH_LOW: begin
          if (halfEnd) begin
            halfCnt <= '0;
            if (lastBit) begin
              phase <= PH_IDLE;
              done  <= 1'b1;
            end else begin
              bitCnt <= bitCnt + 1'b1;
              phase  <= PH_SETUP;
            end
          end else begin
            halfCnt <= halfCnt + 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.load    = (phase == PH_IDLE) && startReq;
    strb.advance = (phase == PH_LOW) && halfEnd;
    strb.sample  = (phase == PH_SETUP) && halfEnd && isRead && (bitCnt >= BIT_DATA);
    strb.commit  = (phase == PH_LOW) && halfEnd && lastBit && isRead;
  end

  assign busy = (phase != PH_IDLE);
  assign sclk = (phase != PH_LOW);

  // R9: completion pulse lasts a single cycle
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R9: busy only drops together with done
  a_r9_busy_fall_done: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);
  // R7: a sample is always followed by the clock falling
  a_r7_sample_then_fall: assert property (@(posedge clk) disable iff (!rstN)
    strb.sample |=> !sclk);
endmodule

// File: rtl/snm_datapath.sv
module snm_datapath
  import snm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  snm_strobe_t       strb,
  input  logic              rdNotWr,
  input  logic [NIBBLE-1:0] regAddr,
  input  logic [NIBBLE-1:0] wrData,
  input  logic              sdIn,
  output logic              sdOut,
  output logic              sdOe,
  output logic [NIBBLE-1:0] rdData
);
  logic [FRAME_BITS-1:0] frame;
  logic [FRAME_BITS-1:0] oeMask;
  logic [NIBBLE-1:0]     capt;
  logic [FRAME_BITS-1:0] newFrame;
  logic [FRAME_BITS-1:0] newMask;

  always_comb begin
    if (rdNotWr) begin
      newFrame = {CTL_READ, regAddr, {(2*NIBBLE){1'b0}}};
      newMask  = {{(2*NIBBLE){1'b1}}, {(2*NIBBLE){1'b0}}};
    end else begin
      newFrame = {CTL_WR_ADDR, regAddr, CTL_WR_DATA, wrData};
      newMask  = {FRAME_BITS{1'b1}};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frame  <= '0;
      oeMask <= '0;
    end else if (strb.load) begin
      frame  <= newFrame;
      oeMask <= newMask;
    end else if (strb.advance) begin
      frame  <= {frame[FRAME_BITS-2:0], 1'b0};
      oeMask <= {oeMask[FRAME_BITS-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capt   <= '0;
      rdData <= '0;
    end else begin
      if (strb.sample) capt <= {capt[NIBBLE-2:0], sdIn};
      if (strb.commit) rdData <= capt;
    end
  end

  assign sdOe  = oeMask[FRAME_BITS-1];
  assign sdOut = frame[FRAME_BITS-1] & oeMask[FRAME_BITS-1];

  // R4: once released, the line stays released until a new frame loads
  a_r4_stay_released: assert property (@(posedge clk) disable iff (!rstN)
    (!sdOe && !strb.load) |=> !sdOe);
endmodule

// File: rtl/serial_nibble_master.sv
module serial_nibble_master
  import snm_pkg::*;
#(
  parameter int HALF_CYC = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       rdNotWr,
  input  logic [3:0] regAddr,
  input  logic [3:0] wrData,
  output logic       busy,
  output logic       done,
  output logic [3:0] rdData,
  input  logic       ceIn,
  output logic       ceOut,
  output logic       sclk,
  output logic       sdOut,
  output logic       sdOe,
  input  logic       sdIn
);
  snm_strobe_t strb;

  snm_ctrl #(.HALF_CYC(HALF_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .rdNotWr(rdNotWr),
    .strb(strb), .busy(busy), .done(done), .sclk(sclk)
  );

  snm_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .rdNotWr(rdNotWr),
    .regAddr(regAddr), .wrData(wrData), .sdIn(sdIn),
    .sdOut(sdOut), .sdOe(sdOe), .rdData(rdData)
  );

  always_ff @(posedge clk) begin
    if (!rstN) ceOut <= 1'b0;
    else       ceOut <= ceIn;
  end

  // R12: line is never driven while idle
  a_r12_oe_idle: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !sdOe);
  // R10: read data only moves on completion
  a_r10_rd_hold: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rdData) |-> done);
endmodule

// File: tb/serial_nibble_master_bench.sv
module serial_nibble_master_bench;
  localparam int H = 3;
  localparam int ACC = 16 * 2 * H;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0, rdNotWr = 1'b0, ceIn = 1'b0, sdIn = 1'b1;
  logic [3:0] regAddr = '0, wrData = '0;
  logic busy, done, ceOut, sclk, sdOut, sdOe;
  logic [3:0] rdData;

  int tests = 0, fails = 0, cyc = 0;

  always #10 clk = ~clk;

  serial_nibble_master #(.HALF_CYC(H)) u_serial_nibble_master (
    .clk(clk), .rstN(rstN), .startReq(startReq), .rdNotWr(rdNotWr),
    .regAddr(regAddr), .wrData(wrData), .busy(busy), .done(done),
    .rdData(rdData), .ceIn(ceIn), .ceOut(ceOut), .sclk(sclk),
    .sdOut(sdOut), .sdOe(sdOe), .sdIn(sdIn)
  );

  // reference model state
  int  t = 0;
  bit  mBusy = 0, mDone = 0, mRd = 0, mCe = 0;
  bit  frameBits[16];
  bit  respBits[8];
  logic [3:0] cap = '0, mRdData = '0;
  logic [3:0] respVal = '0, respJunk = '0;

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rstN) begin
      t = 0; mBusy = 0; mDone = 0; mRd = 0; mCe = 0; cap = '0; mRdData = '0;
    end else begin
      mCe = ceIn;
      mDone = 0;
      if (mBusy) begin
        if (mRd && (t % (2*H)) == H-1 && (t / (2*H)) >= 12) cap = {cap[2:0], sdIn};
        t++;
        if (t == ACC) begin
          mBusy = 0; mDone = 1;
          if (mRd) mRdData = cap;
        end
      end else if (startReq) begin
        mBusy = 1; t = 0; mRd = rdNotWr;
        frameBits[0] = 1; frameBits[1] = rdNotWr; frameBits[2] = 1; frameBits[3] = 0;
        for (int i = 0; i < 4; i++) frameBits[4+i] = regAddr[3-i];
        frameBits[8] = 1; frameBits[9] = 0; frameBits[10] = 0; frameBits[11] = 1;
        for (int i = 0; i < 4; i++) frameBits[12+i] = rdNotWr ? 1'b0 : wrData[3-i];
        for (int i = 0; i < 4; i++) begin
          respBits[i]   = respJunk[3-i];
          respBits[4+i] = respVal[3-i];
        end
      end
    end
  end

  // responder drive and per-cycle comparison
  always @(negedge clk) begin
    int b, ph;
    bit eS, eOe, eOut;
    b = t / (2*H);
    ph = t % (2*H);
    if (mBusy && mRd && b >= 8 && b < 16) sdIn = respBits[b-8];
    else sdIn = 1'b1;
    if (rstN) begin
      eS = !mBusy || ph < H;
      eOe = mBusy && (!mRd || b < 8);
      eOut = eOe ? frameBits[b] : 1'b0;
      chk("R6 sclk", sclk, eS);
      chk("R12/R4 sdOe", sdOe, eOe);
      if (b < 4) chk("R2 control bit", sdOut, eOut);
      else if (b < 8) chk("R3 address bit", sdOut, eOut);
      else if (mRd) chk("R4 released line", sdOut, eOut);
      else chk("R5 write tail bit", sdOut, eOut);
      chk("R8 busy", busy, mBusy);
      chk("R9 done", done, mDone);
      chk("R10/R7 rdData", rdData, mRdData);
      chk("R11 ceOut", ceOut, mCe);
    end
  end

  task automatic waitDone();
    @(negedge clk);
    while (!mDone) @(negedge clk);
  endtask

  task automatic access(bit rd, logic [3:0] a, logic [3:0] d);
    @(negedge clk);
    rdNotWr = rd; regAddr = a; wrData = d; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    waitDone();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset sclk", sclk, 1);
    chk("R1 reset sdOe", sdOe, 0);
    chk("R1 reset sdOut", sdOut, 0);
    chk("R1 reset busy", busy, 0);
    chk("R1 reset done", done, 0);
    chk("R1 reset rdData", rdData, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle after reset", {busy, sclk, sdOe}, 3'b010);

    access(0, 4'h5, 4'hA);                 // R5 write
    respJunk = 4'b1010; respVal = 4'h6;
    access(1, 4'hC, 4'h0);                 // R4 read
    chk("R4 read result", rdData, 4'h6);

    // R8: start pulses in the middle of an access are ignored
    respJunk = 4'b0101; respVal = 4'h9;
    @(negedge clk);
    rdNotWr = 1; regAddr = 4'h3; startReq = 1;
    @(negedge clk);
    startReq = 0;
    repeat (40) @(negedge clk);
    rdNotWr = 0; regAddr = 4'hE; wrData = 4'h7; startReq = 1;
    @(negedge clk);
    startReq = 0;
    waitDone();
    chk("R8 first read kept", rdData, 4'h9);
    @(negedge clk);
    chk("R8 no second access", busy, 0);

    access(0, 4'hF, 4'h0);                 // R10 write keeps rdData
    chk("R10 rdData held after write", rdData, 4'h9);

    // R9 back-to-back with start held high
    respJunk = 4'b1111; respVal = 4'h0;
    @(negedge clk);
    rdNotWr = 1; regAddr = 4'h8; startReq = 1;
    waitDone();
    @(negedge clk);
    rdNotWr = 0; regAddr = 4'h1; wrData = 4'hF;
    chk("R9 restart after done", busy, 1);
    startReq = 0;
    waitDone();
    chk("R4 zero read", rdData, 4'h0);

    // R11 chip enable follows input
    ceIn = 1; repeat (3) @(negedge clk);
    ceIn = 0; @(negedge clk);
    ceIn = 1; repeat (2) @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog expired: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule